// File: doc/BRIEF.md
# Flow Slot Aging and Occupancy Manager

This block keeps a liveness age for every slot of a flow table. A small age code sits beside each row. A sweep pointer walks the rows without end and lowers the age of each row it visits. A row that runs out of age is marked as waiting for removal. The block then sends a delete command with that row's index to the lookup table and to the record store. When the lookup table confirms the removal, the row becomes empty again.

Each lookup hit or new flow refreshes its row to the top age. The block also tells the record store whether that access updates an existing record or creates a new one. It keeps a count of occupied rows. When that count rises above a software threshold, the sweep stops waiting for its programmed interval and advances on every cycle, so old flows are cleared sooner. The table memories themselves are outside this block.

Top module: `flow_age_mgr`

## Requirements
- R1: After reset every row is empty, the sweep pointer is at row 0, the occupancy is 0, and rec_valid, del_valid and fast_mode are low.
- R2: Outside fast mode the pointer visits one row after every cfg_interval+1 cycles. It wraps from the last row to row 0, and it still advances when a refresh takes that row.
- R3: The age codes are 0 for empty, 1 for pending delete, and 2 to 7 for live rows. When the sweep visits a row with code 3 to 7, that code drops by one. Code 2 becomes 1, and del_valid pulses one cycle later with del_row set to that row. Codes 0 and 1 are left unchanged.
- R4: A refresh (ref_valid with ref_row) sets the row's code to 7. One cycle later rec_valid is high with rec_row set to that row. rec_kind is 2'b10 (create) if the row was empty and 2'b01 (update) if the row was live.
- R5: A refresh aimed at a row with code 1 is ignored. No rec_valid follows, the code stays 1, and the occupancy does not change.
- R6: When a refresh and a sweep visit hit the same row in the same cycle, the refresh wins. The row goes to 7 and no delete is issued for it.
- R7: del_ack with ack_row on a row with code 1 empties that row and lowers the occupancy by one. An acknowledge for any other code is ignored.
- R8: occupancy goes up by one for each create and down by one for each accepted acknowledge. Both in the same cycle leave it unchanged.
- R9: fast_mode is high while occupancy > cfg_high. While it is high, the pointer advances on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | RATE_W | Idle cycles between sweep steps in normal mode |
| cfg_high | input | CW | Occupancy threshold for fast mode |
| ref_valid | input | 1 | Flow matched or created this cycle |
| ref_row | input | AW | Row of the refreshed flow |
| del_ack | input | 1 | Lookup table confirms a removal |
| ack_row | input | AW | Row being confirmed |
| rec_valid | output | 1 | Record store access follows |
| rec_kind | output | 2 | 2'b01 update, 2'b10 create |
| rec_row | output | AW | Row of the record access |
| del_valid | output | 1 | Delete command to table and store |
| del_row | output | AW | Row to delete |
| occupancy | output | CW | Number of non-empty rows |
| fast_mode | output | 1 | Aggressive sweep active |

## Verification
The record-access and delete outputs are registered, so they are due exactly one cycle after the edge that sampled the refresh or the sweep visit. occupancy changes at that same edge, and fast_mode follows it combinationally. The bench drives inputs at the falling edge and steps a bench-side model of the ages, pointer and interval counter with those inputs. At the next falling edge it compares every output with the model's values for that one edge. Random refreshes are biased toward the row under the pointer, and acknowledges toward pending rows, so the refresh-over-sweep priority and the acknowledge paths occur often.

// File: rtl/flow_age_mgr.sv
module flow_age_mgr #(
  parameter int ROWS   = 16,
  parameter int RATE_W = 12,
  localparam int AW = $clog2(ROWS),
  localparam int CW = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] cfg_interval,
  input  logic [CW-1:0]     cfg_high,
  input  logic              ref_valid,
  input  logic [AW-1:0]     ref_row,
  input  logic              del_ack,
  input  logic [AW-1:0]     ack_row,
  output logic              rec_valid,
  output logic [1:0]        rec_kind,
  output logic [AW-1:0]     rec_row,
  output logic              del_valid,
  output logic [AW-1:0]     del_row,
  output logic [CW-1:0]     occupancy,
  output logic              fast_mode
);
  localparam logic [2:0] A_EMPTY = 3'd0;
  localparam logic [2:0] A_PEND  = 3'd1;
  localparam logic [2:0] A_LAST  = 3'd2;
  localparam logic [2:0] A_FULL  = 3'd7;
  localparam logic [1:0] K_UPD   = 2'b01;
  localparam logic [1:0] K_NEW   = 2'b10;

  logic [2:0]        age [ROWS];
  logic [AW-1:0]     ptr;
  logic [RATE_W-1:0] cnt;

  logic [2:0] cur, ref_age;
  logic       tick, ref_ok, create, hit, expire, ack_ok;

  assign fast_mode = occupancy > cfg_high;
  assign tick      = fast_mode || (cnt >= cfg_interval);
  assign cur       = age[ptr];
  assign ref_age   = age[ref_row];
  assign ref_ok    = ref_valid && (ref_age != A_PEND);
  assign create    = ref_ok && (ref_age == A_EMPTY);
  assign hit       = tick && !(ref_ok && ref_row == ptr);
  assign expire    = hit && (cur == A_LAST);
  assign ack_ok    = del_ack && (age[ack_row] == A_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) age[i] <= A_EMPTY;
    end else begin
      for (int i = 0; i < ROWS; i++) begin
        if (ref_ok && ref_row == AW'(i))
          age[i] <= A_FULL;
        else if (hit && ptr == AW'(i) && cur >= A_LAST)
          age[i] <= (cur == A_LAST) ? A_PEND : cur - 3'd1;
        else if (ack_ok && ack_row == AW'(i))
          age[i] <= A_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (tick) begin
      ptr <= ptr + AW'(1);
      cnt <= '0;
    end else begin
      cnt <= cnt + RATE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      occupancy <= '0;
    else if (create && !ack_ok)
      occupancy <= occupancy + CW'(1);
    else if (ack_ok && !create)
      occupancy <= occupancy - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_kind  <= 2'b00;
      rec_row   <= '0;
      del_valid <= 1'b0;
      del_row   <= '0;
    end else begin
      rec_valid <= ref_ok;
      rec_kind  <= create ? K_NEW : K_UPD;
      rec_row   <= ref_row;
      del_valid <= expire;
      del_row   <= ptr;
    end
  end
endmodule

module flow_age_chk #(
  parameter int ROWS = 16,
  parameter int AW = 4,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_valid,
  input logic          del_ack,
  input logic          rec_valid,
  input logic [1:0]    rec_kind,
  input logic [CW-1:0] occupancy,
  input logic          fast_mode,
  input logic [AW-1:0] ptr
);
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + AW'(1)));

  p_fast_sweep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fast_mode) |-> (ptr == $past(ptr) + AW'(1)));

  p_rec_follows_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(ref_valid));

  p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_kind == 2'b01 || rec_kind == 2'b10));

  p_occ_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy > $past(occupancy)) |-> (rec_valid && rec_kind == 2'b10));

  p_occ_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy < $past(occupancy)) |-> $past(del_ack));

  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(ROWS));
endmodule

bind flow_age_mgr flow_age_chk #(.ROWS(ROWS), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .del_ack(del_ack),
  .rec_valid(rec_valid), .rec_kind(rec_kind), .occupancy(occupancy),
  .fast_mode(fast_mode), .ptr(ptr)
);

// File: tb/sim_flow_age_mgr.sv
module sim_flow_age_mgr;
  localparam int ROWS = 16;
  localparam int RATE_W = 12;
  localparam int AW = 4;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RATE_W-1:0] cfg_interval = '0;
  logic [CW-1:0] cfg_high = CW'(ROWS);
  logic ref_valid = 1'b0, del_ack = 1'b0;
  logic [AW-1:0] ref_row = '0, ack_row = '0;
  logic rec_valid, del_valid, fast_mode;
  logic [1:0] rec_kind;
  logic [AW-1:0] rec_row, del_row;
  logic [CW-1:0] occupancy;

  always #5 clk = ~clk;

  flow_age_mgr #(.ROWS(ROWS), .RATE_W(RATE_W)) u0 (.*);

  int checks = 0, errors = 0;
  logic [2:0] m_age [ROWS];
  int m_ptr, m_cnt, m_occ;
  logic e_rv, e_dv;
  logic [1:0] e_rk;
  int e_rr, e_dr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ROWS; i++) m_age[i] = 3'd0;
    m_ptr = 0; m_cnt = 0; m_occ = 0;
    e_rv = 0; e_dv = 0; e_rk = 0; e_rr = 0; e_dr = 0;
  endtask

  task automatic model_step();
    bit fast, tick, ref_ok, create, hit, ack_ok;
    logic [2:0] cur, ra;
    fast = m_occ > int'(cfg_high);
    tick = fast || (m_cnt >= int'(cfg_interval));
    ra = m_age[ref_row];
    ref_ok = ref_valid && ra != 3'd1;
    create = ref_ok && ra == 3'd0;
    hit = tick && !(ref_ok && int'(ref_row) == m_ptr);
    cur = m_age[m_ptr];
    ack_ok = del_ack && m_age[ack_row] == 3'd1;
    e_rv = ref_ok; e_rk = create ? 2'b10 : 2'b01; e_rr = int'(ref_row);
    e_dv = hit && cur == 3'd2; e_dr = m_ptr;
    if (hit && cur >= 3'd2) m_age[m_ptr] = (cur == 3'd2) ? 3'd1 : cur - 3'd1;
    if (ack_ok) m_age[ack_row] = 3'd0;
    if (ref_ok) m_age[ref_row] = 3'd7;
    m_occ = m_occ + int'(create) - int'(ack_ok);
    if (tick) begin m_cnt = 0; m_ptr = (m_ptr + 1) % ROWS; end
    else m_cnt++;
  endtask

  task automatic compare();
    chk(rec_valid == e_rv, "R4 R5 rec_valid", int'(rec_valid), int'(e_rv));
    if (e_rv) begin
      chk(rec_kind == e_rk, "R4 rec_kind", int'(rec_kind), int'(e_rk));
      chk(int'(rec_row) == e_rr, "R4 rec_row", int'(rec_row), e_rr);
    end
    chk(del_valid == e_dv, "R3 R6 R2 del_valid", int'(del_valid), int'(e_dv));
    if (e_dv) chk(int'(del_row) == e_dr, "R3 R2 del_row", int'(del_row), e_dr);
    chk(int'(occupancy) == m_occ, "R7 R8 occupancy", int'(occupancy), m_occ);
    chk(fast_mode == (m_occ > int'(cfg_high)), "R9 fast_mode", int'(fast_mode),
        int'(m_occ > int'(cfg_high)));
  endtask

  function automatic int find_pending(input int start);
    for (int k = 0; k < ROWS; k++)
      if (m_age[(start + k) % ROWS] == 3'd1) return (start + k) % ROWS;
    return -1;
  endfunction

  task automatic drive_random(input int ref_pct);
    int p;
    ref_valid = ($urandom % 100) < ref_pct;
    ref_row = ($urandom % 4 == 0) ? AW'(m_ptr) : AW'($urandom % ROWS);
    del_ack = ($urandom % 100) < 40;
    p = find_pending($urandom % ROWS);
    ack_row = (p >= 0 && $urandom % 4 != 0) ? AW'(p) : AW'($urandom % ROWS);
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, dummy;
    dummy = $urandom(32'h5eed_1234);
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rec_valid == 0 && del_valid == 0, "R1 outputs idle", int'(rec_valid | del_valid), 0);
    chk(occupancy == 0, "R1 occupancy", int'(occupancy), 0);
    chk(fast_mode == 0, "R1 fast_mode", int'(fast_mode), 0);
    rst_n = 1'b1;

    // directed: create then update of row 5 with sweep stalled
    cfg_interval = 12'd4095;
    ref_valid = 1; ref_row = 4'd5; model_step(); cycle();
    ref_valid = 1; ref_row = 4'd5; model_step(); cycle();
    chk(rec_kind == 2'b01, "R4 second refresh is update", int'(rec_kind), 1);
    ref_valid = 0; model_step(); cycle();

    // random phases: interval and threshold vary
    for (int ph = 0; ph < 8; ph++) begin
      cfg_interval = RATE_W'((ph % 4 == 0) ? 0 : (ph % 4 == 1) ? 1 : (ph % 4 == 2) ? 3 : $urandom % 7);
      cfg_high = (ph % 2 == 0) ? CW'(ROWS) : CW'(3 + $urandom % 6);
      for (int c = 0; c < 1500; c++) begin
        drive_random((ph % 3 == 0) ? 10 : 35);
        model_step();
        cycle();
      end
    end

    // directed R5: refresh of a pending row is ignored
    cfg_high = CW'(ROWS); cfg_interval = 12'd4095;
    ref_valid = 0; del_ack = 0; model_step(); cycle();
    p = find_pending(0);
    if (p < 0) begin
      cfg_interval = 0;
      ref_valid = 1; ref_row = AW'((m_ptr + 2) % ROWS); model_step(); cycle();
      ref_valid = 0;
      for (int c = 0; c < 6 * ROWS && find_pending(0) < 0; c++) begin model_step(); cycle(); end
      cfg_interval = 12'd4095; model_step(); cycle();
      p = find_pending(0);
    end
    chk(p >= 0, "R3 pending row reached", p, 0);
    if (p >= 0) begin
      ref_valid = 1; ref_row = AW'(p); model_step(); cycle();
      chk(rec_valid == 0, "R5 refresh on pending row ignored", int'(rec_valid), 0);
      ref_valid = 0; model_step(); cycle();
      // R7: acknowledge a non-pending row is ignored, then the pending one
      del_ack = 1; ack_row = AW'((p + 1) % ROWS);
      if (m_age[ack_row] == 3'd1) ack_row = AW'(p);
      model_step(); cycle();
      del_ack = 1; ack_row = AW'(p); model_step(); cycle();
      del_ack = 0;
      ref_valid = 1; ref_row = AW'(p); model_step(); cycle();
      chk(rec_kind == 2'b10, "R7 acknowledged row is empty again", int'(rec_kind), 2);
      ref_valid = 0; model_step(); cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule